// File: doc/BRIEF.md
# Staged Power-Gating Wake-Up Sequencer

This block is a synchronous controller that drives the gate enables of the power switches surrounding a gated logic island. It does not turn every sleep switch on at once. It moves the island from sleep to active through a timed intermediate mode. In that mode only a weak parallel device conducts, so the virtual supply and ground rails settle in two smaller steps and ground bounce stays low. A parameter chooses among three switch arrangements:

- a footer with a parallel park device;
- main header and footer pairs, each with a parallel hold device;
- a header and footer with a parallel doze device.

A sleep request takes priority at all times. It aborts a wake-up that is in progress and restores the all-off pattern in the next cycle.

The controller produces two views of the switch state. `sw_en` carries active-high logical requests for each switch. `sw_gate` carries the physical gate levels, with p-type devices driven inverted. Both are registered, so no combinational glitch can reach a switch. `ready` tells downstream logic that the island has been fully powered for at least one cycle. Control pins are plain levels and have no handshake.

Top module: `pg_wake_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sw_en` is 4'b0000, `sw_gate` is 4'b1001, `mode` is 0 (sleep) and `ready` is 0.
- R2: The switch slots are fixed:
  - bit 0 is the main header (p-type);
  - bit 1 is the main footer (n-type);
  - bit 2 is the header-side parallel device (n-type);
  - bit 3 is the footer-side parallel device (p-type).
  
  `sw_gate` always equals `sw_en` XOR 4'b1001.
- R3: With ARRANGE=0 (park), `sw_en` is 4'b0000 in sleep, 4'b1000 in the intermediate mode and 4'b0010 in active.
- R4: With ARRANGE=1 (dual switch), `sw_en` is 4'b0000 in sleep, 4'b1100 in the intermediate mode and 4'b0011 in active.
- R5: With ARRANGE=2 (doze), `sw_en` is 4'b0000 in sleep, 4'b1001 in the intermediate mode and 4'b0011 in active.
- R6: In sleep, `wake_req`=1 with `sleep_req`=0 at a clock edge makes `mode`=1 (intermediate) after that edge.
- R7: The intermediate mode lasts exactly DWELL_CYCLES cycles if it is not aborted. `mode`=2 (active) follows.
- R8: `sleep_req`=1 at an edge in the intermediate or active mode gives `mode`=0 and `sw_en`=0 after that edge. In sleep, `sleep_req` overrides `wake_req` and the block stays in sleep.
- R9: `ready` is 1 exactly in active cycles whose previous cycle was also active. It is 0 in the first active cycle and in every sleep or intermediate cycle.
- R10: `wake_req` in the intermediate or active mode has no effect. Neither the mode, nor the dwell timing, nor the outputs change because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_req | input | 1 | Request to power the island up |
| sleep_req | input | 1 | Request to power the island down; dominates wake_req |
| sw_en | output | 4 | Logical switch enables, active high, slots as in R2 |
| sw_gate | output | 4 | Physical gate levels, p-type slots inverted |
| ready | output | 1 | Island fully powered and settled |
| mode | output | 2 | 0 sleep, 1 intermediate, 2 active |

## Verification
The bench builds three instances side by side, one per arrangement, all with DWELL_CYCLES=4. They share their inputs, so every random or directed step compares the three switch patterns against one mode trajectory. The short dwell lets random sleep requests abort the intermediate mode at every counter position. It also lets wake requests arrive while the dwell is running, and the bench checks that they change nothing.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_MID   = 2'd1,
    MODE_ACT   = 2'd2
  } pg_mode_e;

  localparam int ARR_PARK = 0;
  localparam int ARR_DUAL = 1;
  localparam int ARR_DOZE = 2;

  localparam int NSW = 4;
  // slots whose device is p-type: main header (0) and footer-side parallel (3)
  localparam logic [NSW-1:0] PTYPE_MASK = 4'b1001;
endpackage

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm
  import pg_pkg::*;
#(
  parameter int DWELL_CYCLES = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wake_req,
  input  logic     sleep_req,
  output pg_mode_e state_q,
  output pg_mode_e state_nxt
);
  localparam int CNT_W = (DWELL_CYCLES < 2) ? 1 : $clog2(DWELL_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    unique case (state_q)
      MODE_SLEEP: begin
        if (!sleep_req && wake_req) begin
          state_nxt = MODE_MID;
          cnt_nxt   = '0;
        end
      end
      MODE_MID: begin
        if (sleep_req) begin
          state_nxt = MODE_SLEEP;
        end else if (cnt_q == LAST) begin
          state_nxt = MODE_ACT;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      MODE_ACT: begin
        if (sleep_req) state_nxt = MODE_SLEEP;
      end
      default: state_nxt = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MODE_SLEEP;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nxt;
      cnt_q   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/pg_pattern_map.sv
module pg_pattern_map
  import pg_pkg::*;
#(
  parameter int ARRANGE = ARR_DOZE
) (
  input  pg_mode_e       mode,
  output logic [NSW-1:0] en
);
  generate
    if (ARRANGE == ARR_PARK) begin : g_park
      always_comb begin
        unique case (mode)
          MODE_MID: en = 4'b1000;
          MODE_ACT: en = 4'b0010;
          default:  en = 4'b0000;
        endcase
      end
    end else if (ARRANGE == ARR_DUAL) begin : g_dual
      always_comb begin
        unique case (mode)
          MODE_MID: en = 4'b1100;
          MODE_ACT: en = 4'b0011;
          default:  en = 4'b0000;
        endcase
      end
    end else begin : g_doze
      always_comb begin
        unique case (mode)
          MODE_MID: en = 4'b1001;
          MODE_ACT: en = 4'b0011;
          default:  en = 4'b0000;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/pg_drive_stage.sv
module pg_drive_stage
  import pg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  pg_mode_e       cur_mode,
  input  pg_mode_e       nxt_mode,
  input  logic [NSW-1:0] pat_nxt,
  output logic [NSW-1:0] sw_en,
  output logic [NSW-1:0] sw_gate,
  output logic           ready,
  output logic [1:0]     mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en <= '0;
      ready <= 1'b0;
      mode  <= MODE_SLEEP;
    end else begin
      sw_en <= pat_nxt;
      ready <= (cur_mode == MODE_ACT) && (nxt_mode == MODE_ACT);
      mode  <= nxt_mode;
    end
  end

  for (genvar i = 0; i < NSW; i++) begin : g_gate
    if (PTYPE_MASK[i]) begin : g_p
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_gate[i] <= 1'b1;
        else        sw_gate[i] <= ~pat_nxt[i];
      end
    end else begin : g_n
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sw_gate[i] <= 1'b0;
        else        sw_gate[i] <= pat_nxt[i];
      end
    end
  end
endmodule

// File: rtl/pg_wake_seq.sv
module pg_wake_seq
  import pg_pkg::*;
#(
  parameter int ARRANGE      = ARR_DOZE,
  parameter int DWELL_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wake_req,
  input  logic       sleep_req,
  output logic [3:0] sw_en,
  output logic [3:0] sw_gate,
  output logic       ready,
  output logic [1:0] mode
);
  pg_mode_e       state_q, state_nxt;
  logic [NSW-1:0] pat_nxt;

  pg_seq_fsm #(.DWELL_CYCLES(DWELL_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .wake_req  (wake_req),
    .sleep_req (sleep_req),
    .state_q   (state_q),
    .state_nxt (state_nxt)
  );

  pg_pattern_map #(.ARRANGE(ARRANGE)) u_map (
    .mode (state_nxt),
    .en   (pat_nxt)
  );

  pg_drive_stage u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_mode (state_q),
    .nxt_mode (state_nxt),
    .pat_nxt  (pat_nxt),
    .sw_en    (sw_en),
    .sw_gate  (sw_gate),
    .ready    (ready),
    .mode     (mode)
  );
endmodule

// File: rtl/pg_wake_seq_chk.sv
module pg_wake_seq_chk #(
  parameter int ARRANGE      = 2,
  parameter int DWELL_CYCLES = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wake_req,
  input logic       sleep_req,
  input logic [3:0] sw_en,
  input logic [3:0] sw_gate,
  input logic       ready,
  input logic [1:0] mode
);
  localparam logic [3:0] MID_PAT = (ARRANGE == 0) ? 4'b1000 :
                                   (ARRANGE == 1) ? 4'b1100 : 4'b1001;
  localparam logic [3:0] ACT_PAT = (ARRANGE == 0) ? 4'b0010 : 4'b0011;

  int unsigned mid_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mid_run <= 0;
    else if (mode == 2'd1) mid_run <= mid_run + 1;
    else                  mid_run <= 0;
  end

  assert_reset_off_R1: assert property (@(posedge clk)
    !rst_n |=> (sw_en == 4'b0000 && mode == 2'd0 && !ready));

  assert_gate_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_gate == (sw_en ^ 4'b1001));

  assert_sleep_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (sw_en == 4'b0000));

  generate
    if (ARRANGE == 0) begin : g_a_park
      assert_park_mid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (sw_en == MID_PAT));
      assert_park_act_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (sw_en == ACT_PAT));
    end else if (ARRANGE == 1) begin : g_a_dual
      assert_dual_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (sw_en == MID_PAT));
      assert_dual_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (sw_en == ACT_PAT));
    end else begin : g_a_doze
      assert_doze_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (sw_en == MID_PAT));
      assert_doze_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (sw_en == ACT_PAT));
    end
  endgenerate

  assert_wake_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && wake_req && !sleep_req) |=> (mode == 2'd1));

  assert_dwell_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd1) |-> (mid_run == DWELL_CYCLES));

  assert_dwell_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (mid_run < DWELL_CYCLES));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0 && sleep_req) |=> (mode == 2'd0 && sw_en == 4'b0000));

  assert_sleep_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req) |=> (mode == 2'd0));

  assert_ready_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mode == 2'd2 && $past(mode) == 2'd2));

  assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && $past(mode) == 2'd2) |-> ready);

  assert_wake_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !sleep_req) |=> (mode == 2'd2));

  assert_no_wake_effect_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !sleep_req) |=> (mode != 2'd0));
endmodule

bind pg_wake_seq pg_wake_seq_chk #(
  .ARRANGE      (ARRANGE),
  .DWELL_CYCLES (DWELL_CYCLES)
) u_chk (.*);

// File: tb/tb_pg_wake_seq.sv
module tb_pg_wake_seq;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wake_req = 1'b0;
  logic sleep_req = 1'b0;

  logic [3:0] en_a [3];
  logic [3:0] gt_a [3];
  logic       rd_a [3];
  logic [1:0] md_a [3];

  always #10 clk = ~clk;

  pg_wake_seq #(.ARRANGE(0), .DWELL_CYCLES(DW)) dut (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .sw_en(en_a[0]), .sw_gate(gt_a[0]), .ready(rd_a[0]), .mode(md_a[0]));
  pg_wake_seq #(.ARRANGE(1), .DWELL_CYCLES(DW)) dut_dual (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .sw_en(en_a[1]), .sw_gate(gt_a[1]), .ready(rd_a[1]), .mode(md_a[1]));
  pg_wake_seq #(.ARRANGE(2), .DWELL_CYCLES(DW)) dut_doze (
    .clk(clk), .rst_n(rst_n), .wake_req(wake_req), .sleep_req(sleep_req),
    .sw_en(en_a[2]), .sw_gate(gt_a[2]), .ready(rd_a[2]), .mode(md_a[2]));

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m_mode = 0;
  int m_cnt = 0;
  bit m_ready = 1'b0;

  function automatic logic [3:0] exp_pat(int arr, int md);
    if (md == 1) return (arr == 0) ? 4'b1000 : (arr == 1) ? 4'b1100 : 4'b1001;
    if (md == 2) return (arr == 0) ? 4'b0010 : 4'b0011;
    return 4'b0000;
  endfunction

  task automatic chk(string req, string what, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_all(string mode_tag);
    for (int a = 0; a < 3; a++) begin
      string pt;
      pt = (a == 0) ? "R3" : (a == 1) ? "R4" : "R5";
      chk(pt, "sw_en", en_a[a], exp_pat(a, m_mode));
      chk("R2", "sw_gate", gt_a[a], exp_pat(a, m_mode) ^ 4'b1001);
      chk(mode_tag, "mode", md_a[a], m_mode);
      chk("R9", "ready", rd_a[a], m_ready);
    end
  endtask

  task automatic step(bit w, bit s);
    int nm;
    int nc;
    string tag;
    @(negedge clk);
    wake_req = w;
    sleep_req = s;
    nm = m_mode;
    nc = m_cnt;
    tag = "R7";
    case (m_mode)
      0: begin
        if (s) tag = "R8";
        else if (w) begin nm = 1; nc = 0; tag = "R6"; end
      end
      1: begin
        if (s) begin nm = 0; tag = "R8"; end
        else begin
          if (w) tag = "R10";
          if (m_cnt == DW - 1) nm = 2;
          else nc = m_cnt + 1;
        end
      end
      default: begin
        if (s) begin nm = 0; tag = "R8"; end
        else if (w) tag = "R10";
      end
    endcase
    @(posedge clk);
    #5;
    m_ready = (m_mode == 2) && (nm == 2);
    m_mode = nm;
    m_cnt = nc;
    check_all(tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(posedge clk);
    #5;
    for (int a = 0; a < 3; a++) begin
      chk("R1", "reset sw_en", en_a[a], 0);
      chk("R1", "reset sw_gate", gt_a[a], 4'b1001);
      chk("R1", "reset mode", md_a[a], 0);
      chk("R1", "reset ready", rd_a[a], 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check_all("R1");

    // R6/R7/R9: full wake, then hold active
    step(1, 0);
    for (int i = 0; i < DW + 3; i++) step(0, 0);
    // R8: sleep from active
    step(0, 1);
    // R8: sleep dominates wake while asleep
    step(1, 1);
    step(0, 0);
    // R8: abort at each dwell position
    for (int k = 0; k < DW; k++) begin
      step(1, 0);
      for (int j = 0; j < k; j++) step(0, 0);
      step(0, 1);
    end
    // R10: wake held high through dwell and active
    for (int i = 0; i < DW + 4; i++) step(1, 0);
    step(0, 1);

    // constrained random
    for (int i = 0; i < 1500; i++) begin
      bit w;
      bit s;
      w = ($urandom % 2) == 0;
      s = ($urandom % 9) == 0;
      step(w, s);
    end

    // reset in the middle of active
    step(1, 0);
    for (int i = 0; i < DW + 2; i++) step(0, 0);
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    m_mode = 0; m_cnt = 0; m_ready = 1'b0;
    check_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule